// File: doc/BRIEF.md
# UART Control Register Bank

This block is the software-visible register file of a UART peripheral. It occupies a 4 KB window on a simple single-cycle bus (valid, write, byte address, write data). The byte address is reduced to a word index by dropping its two low bits. The block stores the configuration words that the rest of the UART uses: the baud divisor pair, the line and control words, the FIFO threshold selection, the interrupt enable mask, the DMA enables and the low-power infrared divisor. It drives all of them out to the neighbouring blocks.

The block owns no FIFO, interrupt logic or transmitter. It assembles the flag word from the FIFO status inputs and passes the raw and masked interrupt status through from the interrupt block. It turns accesses to the data word into one-cycle strobes: a read strobe pops the receive buffer, and a write strobe hands a byte to the transmitter and raises the transmit interrupt source. A short identification table fills the last eight words of the window. Read data is registered, so it appears one cycle after the request.

Top module: `uart_regbank`

## Requirements
- R1: While reset is held, the control word reads 0x300, the FIFO level word reads 0x12, every other stored word is zero, read data is zero and no strobe is active.
- R2: A read presented with bus_valid high and bus_write low returns its value on bus_rdata in the following cycle. After any cycle with no read, bus_rdata is zero.
- R3: Word indices 8 (8 bits), 9 (16 bits), 10 (6 bits), 11 (8 bits), 12 (16 bits), 13 (6 bits), 14 (11 bits) and 18 (3 bits) store the low bits of a write. They read back zero-extended and drive their output ports from the cycle after the write.
- R4: Word index 6 reads tx_empty at bit 7, rx_full at bit 6, tx_full at bit 5 and rx_empty at bit 4, with all other bits zero. Writes to it change no stored word and raise no strobe.
- R5: fifo_enable follows bit 4 of the line control word (index 11).
- R6: A write to index 0 gives, in the next cycle, a one-cycle pulse on data_wr_strobe and on tx_irq_set, with tx_data_out equal to bits 7:0 of the write data.
- R7: A read of index 0 returns rx_data_in zero-extended and gives a one-cycle data_rd_strobe pulse in the next cycle.
- R8: A read of index 1 returns rx_status_in zero-extended. A write to index 1 gives a one-cycle err_clear pulse.
- R9: Reads of index 15 return irq_raw_in and reads of index 16 return irq_masked_in. A write to index 17 gives a one-cycle irq_clear_strobe with irq_clear_out equal to the low 11 write bits. Index 17 reads as zero.
- R10: Byte offsets 0xFE0 to 0xFFC (word indices 0x3F8 to 0x3FF) read the identification bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R11: Reads of any other index return zero. Writes to any other index change no stored word and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_data_in | input | 12 | Head entry of the receive buffer, with its error bits |
| rx_status_in | input | 4 | Receive error status |
| tx_empty_in | input | 1 | Transmit buffer empty |
| rx_full_in | input | 1 | Receive buffer full |
| tx_full_in | input | 1 | Transmit buffer full |
| rx_empty_in | input | 1 | Receive buffer empty |
| irq_raw_in | input | 11 | Raw interrupt status from the interrupt block |
| irq_masked_in | input | 11 | Masked interrupt status from the interrupt block |
| data_rd_strobe | output | 1 | Pop pulse to the receive buffer |
| data_wr_strobe | output | 1 | Push pulse to the transmitter |
| tx_data_out | output | 8 | Byte for the transmitter |
| tx_irq_set | output | 1 | Sets the transmit interrupt source |
| err_clear | output | 1 | Clears the receive error status |
| irq_clear_strobe | output | 1 | Interrupt clear pulse |
| irq_clear_out | output | 11 | Interrupt sources to clear |
| irq_mask_out | output | 11 | Interrupt enable mask |
| ilpr_out | output | 8 | Low-power infrared divisor |
| ibrd_out | output | 16 | Integer baud divisor |
| fbrd_out | output | 6 | Fractional baud divisor |
| lcr_out | output | 8 | Line control word |
| fifo_enable | output | 1 | FIFO enable to the receive buffer |
| ctrl_out | output | 16 | Control word |
| ifls_out | output | 6 | FIFO level selection |
| dmac_out | output | 3 | DMA enable bits |

## Verification
The bound checker checks these rules on every cycle: the pulses that follow data-word and clear writes, the data read strobe, the FIFO enable taking the written bit, zero read data after idle cycles and after reads of undecoded indices, and the first identification byte. Only the bench's scenarios can show that every stored word keeps its value across writes to the flag word and to undecoded indices, that all eight identification bytes come back in order, and that the reset values are correct. The same holds for the readback of each configuration word under random traffic.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_RSR, SEL_FLAG, SEL_ILPR, SEL_IBRD, SEL_FBRD,
    SEL_LCR, SEL_CTRL, SEL_IFLS, SEL_MASK, SEL_RAW, SEL_MIS, SEL_ICLR,
    SEL_DMAC, SEL_ID
  } reg_sel_e;

  localparam int ILPR_W = 8;
  localparam int IBRD_W = 16;
  localparam int FBRD_W = 6;
  localparam int LCR_W  = 8;
  localparam int CTRL_W = 16;
  localparam int IFLS_W = 6;
  localparam int DMAC_W = 3;
  localparam int RSR_W  = 4;

  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
  localparam logic [IFLS_W-1:0] IFLS_RST = 6'h12;
  localparam int FIFO_EN_BIT = 4;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_regbank_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  output reg_sel_e         sel
);

  always_comb begin
    sel = SEL_NONE;
    if (&idx[IDX_W-1:3]) begin
      sel = SEL_ID;
    end else begin
      case (idx)
        IDX_W'(0):  sel = SEL_DATA;
        IDX_W'(1):  sel = SEL_RSR;
        IDX_W'(6):  sel = SEL_FLAG;
        IDX_W'(8):  sel = SEL_ILPR;
        IDX_W'(9):  sel = SEL_IBRD;
        IDX_W'(10): sel = SEL_FBRD;
        IDX_W'(11): sel = SEL_LCR;
        IDX_W'(12): sel = SEL_CTRL;
        IDX_W'(13): sel = SEL_IFLS;
        IDX_W'(14): sel = SEL_MASK;
        IDX_W'(15): sel = SEL_RAW;
        IDX_W'(16): sel = SEL_MIS;
        IDX_W'(17): sel = SEL_ICLR;
        IDX_W'(18): sel = SEL_DMAC;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rb_idrom.sv
module uart_rb_idrom (
  input  logic [2:0] slot,
  output logic [7:0] byte_val
);

  always_comb begin
    case (slot)
      3'd0: byte_val = 8'h11;
      3'd1: byte_val = 8'h10;
      3'd2: byte_val = 8'h14;
      3'd3: byte_val = 8'h00;
      3'd4: byte_val = 8'h0D;
      3'd5: byte_val = 8'hF0;
      3'd6: byte_val = 8'h05;
      default: byte_val = 8'hB1;
    endcase
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RXD_W  = 12,
  parameter int IRQ_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RXD_W-1:0]  rx_data_in,
  input  logic [RSR_W-1:0]  rx_status_in,
  input  logic              tx_empty_in,
  input  logic              rx_full_in,
  input  logic              tx_full_in,
  input  logic              rx_empty_in,
  input  logic [IRQ_W-1:0]  irq_raw_in,
  input  logic [IRQ_W-1:0]  irq_masked_in,
  output logic              data_rd_strobe,
  output logic              data_wr_strobe,
  output logic [7:0]        tx_data_out,
  output logic              tx_irq_set,
  output logic              err_clear,
  output logic              irq_clear_strobe,
  output logic [IRQ_W-1:0]  irq_clear_out,
  output logic [IRQ_W-1:0]  irq_mask_out,
  output logic [ILPR_W-1:0] ilpr_out,
  output logic [IBRD_W-1:0] ibrd_out,
  output logic [FBRD_W-1:0] fbrd_out,
  output logic [LCR_W-1:0]  lcr_out,
  output logic              fifo_enable,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [IFLS_W-1:0] ifls_out,
  output logic [DMAC_W-1:0] dmac_out
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  reg_sel_e          sel;
  logic [7:0]        id_byte;
  logic [DATA_W-1:0] rd_next;
  logic              rd_req;
  logic              wr_req;
  logic              unused_ok;

  assign word_idx  = bus_addr[ADDR_W-1:2];
  assign rd_req    = bus_valid && !bus_write;
  assign wr_req    = bus_valid && bus_write;
  assign unused_ok = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CTRL_W]};

  uart_rb_decode #(.IDX_W(IDX_W)) u_decode (
    .idx (word_idx),
    .sel (sel)
  );

  uart_rb_idrom u_idrom (
    .slot     (word_idx[2:0]),
    .byte_val (id_byte)
  );

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_DATA: rd_next = DATA_W'(rx_data_in);
      SEL_RSR:  rd_next = DATA_W'(rx_status_in);
      SEL_FLAG: rd_next = DATA_W'({tx_empty_in, rx_full_in, tx_full_in, rx_empty_in, 4'b0000});
      SEL_ILPR: rd_next = DATA_W'(ilpr_out);
      SEL_IBRD: rd_next = DATA_W'(ibrd_out);
      SEL_FBRD: rd_next = DATA_W'(fbrd_out);
      SEL_LCR:  rd_next = DATA_W'(lcr_out);
      SEL_CTRL: rd_next = DATA_W'(ctrl_out);
      SEL_IFLS: rd_next = DATA_W'(ifls_out);
      SEL_MASK: rd_next = DATA_W'(irq_mask_out);
      SEL_RAW:  rd_next = DATA_W'(irq_raw_in);
      SEL_MIS:  rd_next = DATA_W'(irq_masked_in);
      SEL_DMAC: rd_next = DATA_W'(dmac_out);
      SEL_ID:   rd_next = DATA_W'(id_byte);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata        <= '0;
      data_rd_strobe   <= 1'b0;
      data_wr_strobe   <= 1'b0;
      tx_irq_set       <= 1'b0;
      err_clear        <= 1'b0;
      irq_clear_strobe <= 1'b0;
      tx_data_out      <= '0;
      irq_clear_out    <= '0;
      irq_mask_out     <= '0;
      ilpr_out         <= '0;
      ibrd_out         <= '0;
      fbrd_out         <= '0;
      lcr_out          <= '0;
      ctrl_out         <= CTRL_RST;
      ifls_out         <= IFLS_RST;
      dmac_out         <= '0;
    end else begin
      bus_rdata        <= rd_req ? rd_next : '0;
      data_rd_strobe   <= rd_req && (sel == SEL_DATA);
      data_wr_strobe   <= 1'b0;
      tx_irq_set       <= 1'b0;
      err_clear        <= 1'b0;
      irq_clear_strobe <= 1'b0;
      if (wr_req) begin
        case (sel)
          SEL_DATA: begin
            data_wr_strobe <= 1'b1;
            tx_irq_set     <= 1'b1;
            tx_data_out    <= bus_wdata[7:0];
          end
          SEL_RSR:  err_clear <= 1'b1;
          SEL_ILPR: ilpr_out  <= bus_wdata[ILPR_W-1:0];
          SEL_IBRD: ibrd_out  <= bus_wdata[IBRD_W-1:0];
          SEL_FBRD: fbrd_out  <= bus_wdata[FBRD_W-1:0];
          SEL_LCR:  lcr_out   <= bus_wdata[LCR_W-1:0];
          SEL_CTRL: ctrl_out  <= bus_wdata[CTRL_W-1:0];
          SEL_IFLS: ifls_out  <= bus_wdata[IFLS_W-1:0];
          SEL_MASK: irq_mask_out <= bus_wdata[IRQ_W-1:0];
          SEL_ICLR: begin
            irq_clear_strobe <= 1'b1;
            irq_clear_out    <= bus_wdata[IRQ_W-1:0];
          end
          SEL_DMAC: dmac_out  <= bus_wdata[DMAC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign fifo_enable = lcr_out[FIFO_EN_BIT];

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              data_rd_strobe,
  input logic              data_wr_strobe,
  input logic [7:0]        tx_data_out,
  input logic              tx_irq_set,
  input logic              irq_clear_strobe,
  input logic [IRQ_W-1:0]  irq_clear_out,
  input logic              fifo_enable
);

  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] cidx;
  logic          is_rd;
  logic          is_wr;
  logic          undec;

  assign cidx  = bus_addr[ADDR_W-1:2];
  assign is_rd = bus_valid && !bus_write;
  assign is_wr = bus_valid && bus_write;
  assign undec = !(&cidx[IW-1:3]) &&
                 !((cidx == IW'(0)) || (cidx == IW'(1)) || (cidx == IW'(6)) ||
                   ((cidx >= IW'(8)) && (cidx <= IW'(16))) || (cidx == IW'(18)));

  // R2
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> (bus_rdata == '0));

  // R6
  a_r6_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    (is_wr && cidx == IW'(0)) |=> (data_wr_strobe && tx_irq_set && tx_data_out == $past(bus_wdata[7:0])));

  // R6
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(is_wr && cidx == IW'(0)) |=> !data_wr_strobe);

  // R7
  a_r7_rd_strobe: assert property (@(posedge clk) disable iff (rst)
    (is_rd && cidx == IW'(0)) |=> data_rd_strobe);

  // R5
  a_r5_fifo_en: assert property (@(posedge clk) disable iff (rst)
    (is_wr && cidx == IW'(11)) |=> (fifo_enable == $past(bus_wdata[4])));

  // R9
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (is_wr && cidx == IW'(17)) |=> (irq_clear_strobe && irq_clear_out == $past(bus_wdata[IRQ_W-1:0])));

  // R10
  a_r10_first_id: assert property (@(posedge clk) disable iff (rst)
    (is_rd && cidx == {{(IW-3){1'b1}}, 3'b000}) |=> (bus_rdata == DATA_W'(8'h11)));

  // R11
  a_r11_undecoded: assert property (@(posedge clk) disable iff (rst)
    (is_rd && undec) |=> (bus_rdata == '0));

endmodule

bind uart_regbank uart_regbank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IRQ_W  (IRQ_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .bus_valid        (bus_valid),
  .bus_write        (bus_write),
  .bus_addr         (bus_addr),
  .bus_wdata        (bus_wdata),
  .bus_rdata        (bus_rdata),
  .data_rd_strobe   (data_rd_strobe),
  .data_wr_strobe   (data_wr_strobe),
  .tx_data_out      (tx_data_out),
  .tx_irq_set       (tx_irq_set),
  .irq_clear_strobe (irq_clear_strobe),
  .irq_clear_out    (irq_clear_out),
  .fifo_enable      (fifo_enable)
);

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] rx_data_in = '0;
  logic [3:0]  rx_status_in = '0;
  logic        tx_empty_in = 1'b1;
  logic        rx_full_in = 1'b0;
  logic        tx_full_in = 1'b0;
  logic        rx_empty_in = 1'b1;
  logic [10:0] irq_raw_in = '0;
  logic [10:0] irq_masked_in = '0;
  logic        data_rd_strobe, data_wr_strobe, tx_irq_set, err_clear, irq_clear_strobe;
  logic [7:0]  tx_data_out;
  logic [10:0] irq_clear_out, irq_mask_out;
  logic [7:0]  ilpr_out, lcr_out;
  logic [15:0] ibrd_out, ctrl_out;
  logic [5:0]  fbrd_out, ifls_out;
  logic [2:0]  dmac_out;
  logic        fifo_enable;

  always #2 clk = ~clk;

  uart_regbank dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data_in(rx_data_in), .rx_status_in(rx_status_in),
    .tx_empty_in(tx_empty_in), .rx_full_in(rx_full_in), .tx_full_in(tx_full_in),
    .rx_empty_in(rx_empty_in), .irq_raw_in(irq_raw_in), .irq_masked_in(irq_masked_in),
    .data_rd_strobe(data_rd_strobe), .data_wr_strobe(data_wr_strobe),
    .tx_data_out(tx_data_out), .tx_irq_set(tx_irq_set), .err_clear(err_clear),
    .irq_clear_strobe(irq_clear_strobe), .irq_clear_out(irq_clear_out),
    .irq_mask_out(irq_mask_out), .ilpr_out(ilpr_out), .ibrd_out(ibrd_out),
    .fbrd_out(fbrd_out), .lcr_out(lcr_out), .fifo_enable(fifo_enable),
    .ctrl_out(ctrl_out), .ifls_out(ifls_out), .dmac_out(dmac_out)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0]  m_ilpr, m_lcr;
  logic [15:0] m_ibrd, m_ctrl;
  logic [5:0]  m_fbrd, m_ifls;
  logic [10:0] m_mask;
  logic [2:0]  m_dmac;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_val(int k);
    case (k)
      0: return 8'h11; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(int idx);
    if (idx >= 'h3F8) return {24'h0, id_val(idx - 'h3F8)};   // R10
    case (idx)
      0:  return {20'h0, rx_data_in};                            // R7
      1:  return {28'h0, rx_status_in};                          // R8
      6:  return {24'h0, tx_empty_in, rx_full_in, tx_full_in, rx_empty_in, 4'h0}; // R4
      8:  return {24'h0, m_ilpr};
      9:  return {16'h0, m_ibrd};
      10: return {26'h0, m_fbrd};
      11: return {24'h0, m_lcr};
      12: return {16'h0, m_ctrl};
      13: return {26'h0, m_ifls};
      14: return {21'h0, m_mask};
      15: return {21'h0, irq_raw_in};                            // R9
      16: return {21'h0, irq_masked_in};
      18: return {29'h0, m_dmac};
      default: return 32'h0;                                     // R11
    endcase
  endfunction

  function automatic string req_of(int idx);
    if (idx >= 'h3F8) return "R10";
    case (idx)
      0: return "R7"; 1: return "R8"; 6: return "R4";
      8, 9, 10, 11, 12, 13, 14, 18: return "R3";
      15, 16, 17: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [127:0] cfg_model();
    return {m_ilpr, m_ibrd, m_fbrd, m_lcr, m_ctrl, m_ifls, m_mask, m_dmac, m_lcr[4]};
  endfunction

  function automatic logic [127:0] cfg_dut();
    return {ilpr_out, ibrd_out, fbrd_out, lcr_out, ctrl_out, ifls_out, irq_mask_out, dmac_out, fifo_enable};
  endfunction

  // Called at a negative edge; returns at the next negative edge.
  task automatic txn(bit w, int idx, logic [31:0] d);
    logic [31:0] exp_rd;
    logic [4:0]  exp_stb;
    rx_data_in    = 12'($urandom);
    rx_status_in  = 4'($urandom);
    {tx_empty_in, rx_full_in, tx_full_in, rx_empty_in} = 4'($urandom);
    irq_raw_in    = 11'($urandom);
    irq_masked_in = 11'($urandom);
    bus_valid = 1'b1;
    bus_write = w;
    bus_addr  = 12'(idx << 2);
    bus_wdata = d;
    exp_rd  = w ? 32'h0 : exp_read(idx);
    exp_stb = {!w && idx == 0, w && idx == 0, w && idx == 0, w && idx == 1, w && idx == 17};
    if (w) begin
      case (idx)
        8:  m_ilpr = d[7:0];
        9:  m_ibrd = d[15:0];
        10: m_fbrd = d[5:0];
        11: m_lcr  = d[7:0];
        12: m_ctrl = d[15:0];
        13: m_ifls = d[5:0];
        14: m_mask = d[10:0];
        18: m_dmac = d[2:0];
        default: ;
      endcase
    end
    @(negedge clk);
    bus_valid = 1'b0;
    check(w ? "R2 rdata after write" : req_of(idx), bus_rdata, exp_rd);
    check("R6 R7 R8 R9 strobes", {data_rd_strobe, data_wr_strobe, tx_irq_set, err_clear, irq_clear_strobe}, exp_stb);
    check(w ? "R3 R4 R5 R11 stored words" : "R3 stored words", cfg_dut(), cfg_model());
    if (w && idx == 0)  check("R6 tx byte", tx_data_out, d[7:0]);
    if (w && idx == 17) check("R9 clear bits", irq_clear_out, d[10:0]);
  endtask

  task automatic idle();
    @(negedge clk);
    check("R2 idle rdata", bus_rdata, 32'h0);
    check("R6 R7 idle strobes", {data_rd_strobe, data_wr_strobe, tx_irq_set, err_clear, irq_clear_strobe}, 5'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ilpr = '0; m_ibrd = '0; m_fbrd = '0; m_lcr = '0;
    m_ctrl = 16'h0300; m_ifls = 6'h12; m_mask = '0; m_dmac = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset stored words", cfg_dut(), cfg_model());
    check("R1 reset rdata", bus_rdata, 32'h0);
    check("R1 reset strobes", {data_rd_strobe, data_wr_strobe, tx_irq_set, err_clear, irq_clear_strobe}, 5'h0);
    rst = 1'b0;
    @(negedge clk);
    txn(0, 12, 0);                  // R1 control reads 0x300
    txn(0, 13, 0);                  // R1 level select reads 0x12
    // R5 FIFO enable on and off
    txn(1, 11, 32'h0000_0010);
    txn(1, 11, 32'hFFFF_FFEF);
    // R4 flag write ignored
    txn(1, 6, 32'hFFFF_FFFF);
    txn(0, 6, 0);
    // R11 undecoded writes and reads
    txn(1, 2, 32'hFFFF_FFFF);
    txn(1, 19, 32'hFFFF_FFFF);
    txn(0, 7, 0);
    txn(0, 'h3F7, 0);
    // R10 all identification bytes
    for (int k = 0; k < 8; k++) txn(0, 'h3F8 + k, 0);
    // R9 clear word reads zero, write pulses
    txn(1, 17, 32'h0000_07FF);
    txn(0, 17, 0);
    // R6 and R7 back to back
    txn(1, 0, 32'h0000_01A5);
    txn(0, 0, 0);
    idle();
    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int pick, idx;
      pick = $urandom_range(0, 21);
      if (pick <= 18)      idx = pick;
      else if (pick == 19) idx = 'h3F8 + $urandom_range(0, 7);
      else if (pick == 20) idx = $urandom_range(19, 'h3F7);
      else                 idx = 6;
      txn(bit'($urandom_range(0, 1)), idx, $urandom);
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule